// File: doc/BRIEF.md
# Relocatable RAM Window Controller

This block is the address decoder and control register set that sits in front of a 4 KB on-chip static RAM whose position in the address map can be changed at run time. Each bus access presents an address, a function code (privilege level plus program or data space), a read/write flag and a byte/word size. The block decides whether the access falls in the RAM window, in its own eight-byte register block, or in neither.

The window base is a 4 KB aligned address held in two 16-bit registers. A two-bit space field selects which combinations of privilege and space the window will serve. A halt bit takes the array offline, and a write-once lock bit freezes the base. When neither target claims an access, the hit output stays low so that logic outside the block can decode it. All outputs are registered and report an access in the cycle after it is presented.

Top module: `ram_window_ctl`

## Requirements
- R1: After reset, halt=1, lock=0, space=00 and both base words are zero. The control word reads 0x8000 and the other three words read 0x0000.
- R2: The register block is eight bytes at REG_BASE and is claimed only by supervisor data accesses (fc=3'b101). Word offsets are 0 for control, 2 for a test word that reads zero and ignores writes, 4 for base high and 6 for base low. Any other function code is not claimed and changes no register.
- R3: The base words take a write only while halt=1 and lock=0. Otherwise the write is discarded. Base high bits 7:0 hold address bits 23:16. Base low bits 15:12 hold address bits 15:12, and its bits 11:0 read zero.
- R4: Control word layout: bit 15 halt, bit 14 lock, bits 1:0 space, all other bits read zero. The lock can only be set by writing a 1 to it. Writing 0 leaves it set until reset.
- R5: fc bit 2 is supervisor. fc[1:0]=01 is data space and 10 is program space. The space field codes are: 00 program+data, any level; 01 program only, any level; 10 program+data, supervisor only; 11 program only, supervisor only. fc[1:0] of 00 or 11 is never claimed by the array.
- R6: An access that is not claimed gives hit=0, array_sel=0, reg_sel=0 and rd_data=0 in the following cycle.
- R7: While halt=1 the array window claims no access.
- R8: An allowed access whose address bits 23:12 equal the base gives array_sel=1 and hit=1 one cycle later, with rd_data=0.
- R9: If the window covers the register block, the array claims the access and reg_sel stays 0.
- R10: A byte write at an even address updates bits 15:8 and a byte write at an odd address updates bits 7:0. The other lane keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address |
| bus_fc | input | 3 | Function code: bit 2 supervisor, bits 1:0 space |
| bus_wr | input | 1 | 1 = write |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Register read data, registered |
| array_sel | output | 1 | Access claimed by the RAM window, registered |
| reg_sel | output | 1 | Access claimed by the register block, registered |
| hit | output | 1 | Access claimed by either target, registered |

## Verification
The hardest state to reach from the ports is a window that overlaps the register block. Once the array is running there, the registers can no longer be reached, so this state cannot be built up step by step and then undone. The bench therefore resets the block first, loads the base with the register block's own 4 KB page while the array is halted, and only then clears halt. The locked state is also sticky, so the bench reaches it late in the run and then uses a reset to check that reset clears it.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    SP_ANY_PD = 2'b00,
    SP_ANY_P  = 2'b01,
    SP_SUP_PD = 2'b10,
    SP_SUP_P  = 2'b11
  } space_t;

  localparam logic [1:0] FC_DATA = 2'b01;
  localparam logic [1:0] FC_PROG = 2'b10;

  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_TEST = 2'd1;
  localparam logic [1:0] IDX_BHI  = 2'd2;
  localparam logic [1:0] IDX_BLO  = 2'd3;

  localparam int BIT_HALT = 15;
  localparam int BIT_LOCK = 14;
endpackage

// File: rtl/rwc_perm.sv
module rwc_perm
  import rwc_pkg::*;
(
  input  logic [2:0] fc,
  input  space_t     space,
  output logic       arr_ok,
  output logic       reg_ok
);
  logic sup, is_prog, is_data, space_fit, level_fit;

  always_comb begin
    sup     = fc[2];
    is_prog = (fc[1:0] == FC_PROG);
    is_data = (fc[1:0] == FC_DATA);
    unique case (space)
      SP_ANY_PD: begin space_fit = is_prog | is_data; level_fit = 1'b1; end
      SP_ANY_P:  begin space_fit = is_prog;           level_fit = 1'b1; end
      SP_SUP_PD: begin space_fit = is_prog | is_data; level_fit = sup;  end
      default:   begin space_fit = is_prog;           level_fit = sup;  end
    endcase
    arr_ok = space_fit & level_fit;
    reg_ok = sup & is_data;
  end
endmodule

// File: rtl/rwc_regs.sv
module rwc_regs
  import rwc_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int BLK_LSB = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [1:0]                idx,
  input  logic [WORD_W-1:0]         wmask,
  input  logic [WORD_W-1:0]         wdata,
  output logic                      halt_o,
  output logic                      lock_o,
  output space_t                    space_o,
  output logic [ADDR_W-BLK_LSB-1:0] tag_o,
  output logic [WORD_W-1:0]         rd_word_o
);
  localparam int TAG_W = ADDR_W - BLK_LSB;
  localparam int LO_W  = WORD_W - BLK_LSB;
  localparam int HI_W  = TAG_W - LO_W;

  logic             halt_q, lock_q;
  space_t           space_q;
  logic [TAG_W-1:0] tag_q;

  logic [WORD_W-1:0] ctrl_word, hi_word, lo_word, cur_word, merged;
  logic              base_open;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_HALT] = halt_q;
    ctrl_word[BIT_LOCK] = lock_q;
    ctrl_word[1:0] = space_q;
    hi_word = '0;
    hi_word[HI_W-1:0] = tag_q[TAG_W-1:LO_W];
    lo_word = '0;
    lo_word[WORD_W-1:BLK_LSB] = tag_q[LO_W-1:0];
    unique case (idx)
      IDX_CTRL: cur_word = ctrl_word;
      IDX_BHI:  cur_word = hi_word;
      IDX_BLO:  cur_word = lo_word;
      default:  cur_word = '0;
    endcase
    merged    = (cur_word & ~wmask) | (wdata & wmask);
    base_open = halt_q & ~lock_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q  <= 1'b1;
      lock_q  <= 1'b0;
      space_q <= SP_ANY_PD;
      tag_q   <= '0;
    end else if (wr_en) begin
      unique case (idx)
        IDX_CTRL: begin
          halt_q  <= merged[BIT_HALT];
          lock_q  <= lock_q | (wmask[BIT_LOCK] & wdata[BIT_LOCK]);
          space_q <= space_t'(merged[1:0]);
        end
        IDX_BHI: if (base_open) tag_q[TAG_W-1:LO_W] <= merged[HI_W-1:0];
        IDX_BLO: if (base_open) tag_q[LO_W-1:0] <= merged[WORD_W-1:BLK_LSB];
        default: ;
      endcase
    end
  end

  assign halt_o    = halt_q;
  assign lock_o    = lock_q;
  assign space_o   = space_q;
  assign tag_o     = tag_q;
  assign rd_word_o = cur_word;

  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  a_r3_base_frozen: assert property (@(posedge clk) disable iff (rst)
    (!halt_q || lock_q) |=> $stable(tag_q));
endmodule

// File: rtl/rwc_decode.sv
module rwc_decode
  import rwc_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter int                BLK_LSB  = 12,
  parameter logic [ADDR_W-1:0] REG_BASE = 24'hFFFB40
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      valid,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      wr,
  input  logic                      arr_ok,
  input  logic                      reg_ok,
  input  logic                      halt,
  input  logic [ADDR_W-BLK_LSB-1:0] tag,
  input  logic [WORD_W-1:0]         rd_word,
  output logic                      reg_wr,
  output logic                      array_sel_q,
  output logic                      reg_sel_q,
  output logic                      hit_q,
  output logic [WORD_W-1:0]         rdata_q
);
  logic arr_hit, reg_hit;

  always_comb begin
    arr_hit = valid & ~halt & arr_ok & (addr[ADDR_W-1:BLK_LSB] == tag);
    reg_hit = valid & reg_ok & (addr[ADDR_W-1:3] == REG_BASE[ADDR_W-1:3]) & ~arr_hit;
    reg_wr  = reg_hit & wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      array_sel_q <= 1'b0;
      reg_sel_q   <= 1'b0;
      hit_q       <= 1'b0;
      rdata_q     <= '0;
    end else begin
      array_sel_q <= arr_hit;
      reg_sel_q   <= reg_hit;
      hit_q       <= arr_hit | reg_hit;
      rdata_q     <= (reg_hit & ~wr) ? rd_word : '0;
    end
  end

  a_r9_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({array_sel_q, reg_sel_q}));
  a_r7_halt_blocks: assert property (@(posedge clk) disable iff (rst)
    halt |=> !array_sel_q);
  a_r2_priv_regs: assert property (@(posedge clk) disable iff (rst)
    (valid && !reg_ok) |=> !reg_sel_q);
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !valid |=> (!hit_q && rdata_q == '0));
endmodule

// File: rtl/ram_window_ctl.sv
module ram_window_ctl
  import rwc_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter int                BLK_LSB  = 12,
  parameter logic [ADDR_W-1:0] REG_BASE = 24'hFFFB40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_fc,
  input  logic              bus_wr,
  input  logic              bus_byte,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              array_sel,
  output logic              reg_sel,
  output logic              hit
);
  localparam int TAG_W = ADDR_W - BLK_LSB;

  logic              halt, lock, arr_ok, reg_ok, reg_wr;
  space_t            space;
  logic [TAG_W-1:0]  tag;
  logic [WORD_W-1:0] rd_word, wmask;

  always_comb begin
    if (!bus_byte)        wmask = 16'hFFFF;
    else if (bus_addr[0]) wmask = 16'h00FF;
    else                  wmask = 16'hFF00;
  end

  rwc_perm u_perm (
    .fc     (bus_fc),
    .space  (space),
    .arr_ok (arr_ok),
    .reg_ok (reg_ok)
  );

  rwc_regs #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr),
    .idx       (bus_addr[2:1]),
    .wmask     (wmask),
    .wdata     (bus_wdata),
    .halt_o    (halt),
    .lock_o    (lock),
    .space_o   (space),
    .tag_o     (tag),
    .rd_word_o (rd_word)
  );

  rwc_decode #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .REG_BASE(REG_BASE)) u_dec (
    .clk         (clk),
    .rst         (rst),
    .valid       (bus_valid),
    .addr        (bus_addr),
    .wr          (bus_wr),
    .arr_ok      (arr_ok),
    .reg_ok      (reg_ok),
    .halt        (halt),
    .tag         (tag),
    .rd_word     (rd_word),
    .reg_wr      (reg_wr),
    .array_sel_q (array_sel),
    .reg_sel_q   (reg_sel),
    .hit_q       (hit),
    .rdata_q     (bus_rdata)
  );

  a_r5_user_barred: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_fc[2] && space[1]) |=> !array_sel);
  a_r4_lock_reset_free: assert property (@(posedge clk)
    rst |=> !lock);
endmodule

// File: tb/ram_window_ctl_tb.sv
module ram_window_ctl_tb;
  localparam logic [23:0] RB = 24'hFFFB40;
  localparam logic [23:0] WIN = 24'h125400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [2:0]  bus_fc = '0;
  logic        bus_wr = 1'b0;
  logic        bus_byte = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        array_sel, reg_sel, hit;

  int total = 0;
  int bad = 0;
  logic [15:0] s_rd;
  logic        s_as, s_rs, s_hit;

  always #4 clk = ~clk;

  ram_window_ctl u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_fc(bus_fc), .bus_wr(bus_wr), .bus_byte(bus_byte),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .array_sel(array_sel), .reg_sel(reg_sel), .hit(hit)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic acc(input logic [23:0] a, input logic [2:0] fc, input logic wr,
                     input logic by, input logic [15:0] wd);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_fc = fc; bus_wr = wr;
    bus_byte = by; bus_wdata = wd;
    @(negedge clk);
    bus_valid = 1'b0; bus_wr = 1'b0;
    s_rd = bus_rdata; s_as = array_sel; s_rs = reg_sel; s_hit = hit;
  endtask

  task automatic wr_reg(input logic [2:0] ofs, input logic [15:0] d);
    acc(RB + 24'(ofs), 3'b101, 1'b1, 1'b0, d);
  endtask

  task automatic rd_reg(input logic [2:0] ofs);
    acc(RB + 24'(ofs), 3'b101, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic allowed(input logic [2:0] fc, input logic [1:0] sp);
    logic prog, data;
    prog = (fc[1:0] == 2'b10);
    data = (fc[1:0] == 2'b01);
    case (sp)
      2'b00: return prog | data;
      2'b01: return prog;
      2'b10: return (prog | data) & fc[2];
      default: return prog & fc[2];
    endcase
  endfunction

  task automatic t_reset;
    rd_reg(3'd0); chk("R1 ctrl", s_rd, 16'h8000);
    chk("R1 reg_sel", {15'b0, s_rs}, 16'h1);
    rd_reg(3'd2); chk("R1 test", s_rd, 16'h0000);
    rd_reg(3'd4); chk("R1 bhi", s_rd, 16'h0000);
    rd_reg(3'd6); chk("R1 blo", s_rd, 16'h0000);
  endtask

  task automatic t_priv;
    acc(RB, 3'b001, 1'b0, 1'b0, 16'h0);
    chk("R2 user data hit", {15'b0, s_hit}, 16'h0);
    chk("R6 rdata", s_rd, 16'h0);
    acc(RB, 3'b110, 1'b0, 1'b0, 16'h0);
    chk("R2 sup prog hit", {15'b0, s_hit}, 16'h0);
    acc(RB, 3'b001, 1'b1, 1'b0, 16'h0000);
    rd_reg(3'd0); chk("R2 user write ignored", s_rd, 16'h8000);
    wr_reg(3'd2, 16'hFFFF);
    rd_reg(3'd2); chk("R2 test raz", s_rd, 16'h0000);
  endtask

  task automatic t_base;
    wr_reg(3'd4, 16'h0012);
    wr_reg(3'd6, 16'h3FFF);
    rd_reg(3'd6); chk("R3 blo low bits zero", s_rd, 16'h3000);
    rd_reg(3'd4); chk("R3 bhi", s_rd, 16'h0012);
    acc(RB + 24'd6, 3'b101, 1'b1, 1'b1, 16'h5000);
    rd_reg(3'd6); chk("R10 even byte", s_rd, 16'h5000);
    acc(RB + 24'd7, 3'b101, 1'b1, 1'b1, 16'h00FF);
    rd_reg(3'd6); chk("R10 odd byte keeps high", s_rd, 16'h5000);
  endtask

  task automatic t_run;
    acc(WIN, 3'b101, 1'b0, 1'b0, 16'h0);
    chk("R7 halted no hit", {15'b0, s_hit}, 16'h0);
    wr_reg(3'd0, 16'h0000);
    acc(WIN, 3'b101, 1'b0, 1'b0, 16'h0);
    chk("R8 array_sel", {15'b0, s_as}, 16'h1);
    chk("R8 hit", {15'b0, s_hit}, 16'h1);
    chk("R8 rdata", s_rd, 16'h0);
    acc(WIN + 24'h1000, 3'b101, 1'b0, 1'b0, 16'h0);
    chk("R6 outside window", {15'b0, s_hit}, 16'h0);
    wr_reg(3'd4, 16'h0077);
    rd_reg(3'd4); chk("R3 running write dropped", s_rd, 16'h0012);
  endtask

  task automatic t_space;
    logic [2:0] fcs [6];
    fcs = '{3'b001, 3'b010, 3'b101, 3'b110, 3'b000, 3'b011};
    for (int sp = 0; sp < 4; sp++) begin
      acc(RB + 24'd1, 3'b101, 1'b1, 1'b1, {14'b0, 2'(sp)});
      rd_reg(3'd0); chk("R10 space byte, halt kept", s_rd, {14'b0, 2'(sp)});
      for (int k = 0; k < 6; k++) begin
        acc(WIN, fcs[k], 1'b0, 1'b0, 16'h0);
        chk($sformatf("R5 sp=%0d fc=%0d", sp, fcs[k]), {15'b0, s_hit},
            {15'b0, allowed(fcs[k], 2'(sp))});
      end
    end
  endtask

  task automatic t_lock;
    wr_reg(3'd0, 16'h8000);
    wr_reg(3'd0, 16'hC000);
    rd_reg(3'd0); chk("R4 lock set", s_rd, 16'hC000);
    wr_reg(3'd4, 16'h0033);
    rd_reg(3'd4); chk("R3 locked write dropped", s_rd, 16'h0012);
    wr_reg(3'd0, 16'h8000);
    rd_reg(3'd0); chk("R4 lock not cleared", s_rd, 16'hC000);
    wr_reg(3'd0, 16'h0002);
    rd_reg(3'd0); chk("R4 other fields writable", s_rd, 16'h4002);
    do_reset;
    rd_reg(3'd0); chk("R1 reset clears lock", s_rd, 16'h8000);
    rd_reg(3'd4); chk("R1 reset clears base", s_rd, 16'h0000);
  endtask

  task automatic t_overlap;
    wr_reg(3'd4, 16'h00FF);
    wr_reg(3'd6, 16'hF000);
    wr_reg(3'd0, 16'h0000);
    rd_reg(3'd0);
    chk("R9 array wins", {15'b0, s_as}, 16'h1);
    chk("R9 reg_sel low", {15'b0, s_rs}, 16'h0);
    chk("R9 rdata", s_rd, 16'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_priv;
    t_base;
    t_run;
    t_space;
    t_lock;
    t_overlap;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule